// File: doc/BRIEF.md
# Frame Template Injector

This block keeps a small library of prepared frames and plays one of them out on demand. Software, or a neighbouring controller, fills a 512-word template store through an offset/data write port. Each stored word is 18 bits wide: a 16-bit payload, a flag that ends the frame, and a flag that asks for the payload to be replaced. The store is divided into eight fixed slots of 64 words each. A slot therefore holds a frame of up to 128 bytes.

A request names a slot and supplies a 16-bit substitution value. The block then emits that slot's words in order on a valid/ready stream. It stops at the first word whose end flag is set, or after the 64th word if no end flag appears. Any word whose replace flag is set goes out as the substitution value captured with the request, not as its stored payload. This lets one stored frame carry a field that is patched at send time, such as a sequence number or a timestamp. While a frame is being sent the block reports busy and ignores further requests.

Top module: `tmpl_inject`

## Requirements
- R1: A write with offset bit 9 set (offsets 512 to 1023) stores its 18-bit value at slot `offset[8:6]`, word `offset[5:0]`. A write with offset bit 9 clear (offsets 0 to 511) changes nothing in the store.
- R2: An accepted request for slot k emits the words of slot k in order from word 0. Each emitted word carries stored bits [15:0] on `out_data`.
- R3: A stored word with bit 16 set is the last word of the frame. `out_eof` is high while it is presented, and `out_valid` is low in the cycle after it is accepted.
- R4: A stored word with bit 17 set is emitted as the `req_user` value sampled in the accepting cycle. Later changes of `req_user` have no effect on the frame.
- R5: If none of the 64 words of a slot has bit 16 set, the 64th word is flagged with `out_eof` and the frame ends there.
- R6: `busy` rises in the cycle after a request is accepted and stays high until the cycle after the final word is accepted. A request raised while `busy` is high is ignored.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` and `out_eof` hold their values.
- R8: With `out_ready` held high, a new word is presented in every cycle from the first word to the last, with no idle cycles between them.
- R9: During and directly after a synchronous active-low reset, `busy` and `out_valid` are low.
- R10: Whenever `out_valid` is low, `out_data` and `out_eof` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Store write strobe |
| wr_offset | input | 10 | Write offset; only the upper half addresses the store |
| wr_data | input | 18 | Word to store: bit 17 replace, bit 16 last, bits [15:0] payload |
| req | input | 1 | Frame request, taken when idle |
| req_idx | input | 3 | Slot to send |
| req_user | input | 16 | Substitution value for replace-flagged words |
| busy | output | 1 | A frame is in progress |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Sink accepts the word |
| out_data | output | 16 | Output word |
| out_eof | output | 1 | Current word ends the frame |

## Verification
The assertions assume that the store is not written to the slot being played while `busy` is high. They also assume that the stored contents of a slot are known before that slot is requested. The stimulus meets both assumptions. It fills every word of a slot that a frame can reach before requesting that slot, and it performs all writes while the block is idle. Back-pressure, requests raised during a frame and the changes to `req_user` after acceptance are applied only through the port handshakes. This keeps the checks on stability and on the absence of bubbles tied to the stream protocol alone.

// File: rtl/tmpl_inject_pkg.sv
// Package: tmpl_inject_pkg
// Shared word layout for the template injector.
// Assumes a 16-bit payload with two control flags above it.
package tmpl_inject_pkg;
    localparam int WORD_W = 16;

    typedef struct packed {
        logic              repl;  // send captured user value instead of payload
        logic              last;  // final word of the template
        logic [WORD_W-1:0] data;  // payload
    } tmpl_word_t;

    localparam int ENTRY_W = $bits(tmpl_word_t);
endpackage

// File: rtl/tmpl_store.sv
// Module: tmpl_store
// Template memory with one write port decoded from a wider offset and
// one registered read port. Only offsets in the upper half of the offset
// range reach the memory. Assumes DEPTH equals half the offset range.
module tmpl_store
    import tmpl_inject_pkg::*;
#(
    parameter int OFFS_W = 10,
    parameter int DEPTH  = 512,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [OFFS_W-1:0] wr_offset,
    input  tmpl_word_t        wr_data,
    input  logic [AW-1:0]     rd_addr,
    output tmpl_word_t        rd_q
);
    tmpl_word_t mem [DEPTH];
    logic       in_region;

    // Decode: the top offset bit selects the template half of the space.
    assign in_region = wr_offset[OFFS_W-1];

    // Write path: store the word when the offset falls in the template half.
    always_ff @(posedge clk) begin
        if (wr_en && in_region) begin
            mem[wr_offset[AW-1:0]] <= wr_data;
        end
    end

    // Read path: one-cycle registered read.
    always_ff @(posedge clk) begin
        rd_q <= mem[rd_addr];
    end
endmodule

// File: rtl/tmpl_seq.sv
// Module: tmpl_seq
// Frame sequencer. Accepts a request when idle, then walks the slot.
// It steers the store read address one word ahead on each handshake,
// so the registered read always holds the word being presented.
// Assumes the store slot is not rewritten while a frame is running.
module tmpl_seq
    import tmpl_inject_pkg::*;
#(
    parameter int NUM_TMPL   = 8,
    parameter int TMPL_DEPTH = 64,
    localparam int IDX_W     = $clog2(NUM_TMPL),
    localparam int CNT_W     = $clog2(TMPL_DEPTH),
    localparam int AW        = IDX_W + CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [WORD_W-1:0] req_user,
    output logic              busy,
    output logic [AW-1:0]     rd_addr,
    input  tmpl_word_t        rd_q,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_eof
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TMPL_DEPTH - 1);

    logic              active;
    logic [IDX_W-1:0]  idx_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] user_q;
    logic              accept;
    logic              fire;
    logic              last_word;

    assign accept    = req && !active;
    assign fire      = active && out_ready;
    assign last_word = rd_q.last || (cnt_q == CNT_MAX);

    // Read steering: fetch word 0 on accept, the next word on a handshake.
    always_comb begin
        if (accept) begin
            rd_addr = {req_idx, {CNT_W{1'b0}}};
        end else if (fire && !last_word) begin
            rd_addr = {idx_q, cnt_q + CNT_W'(1)};
        end else begin
            rd_addr = {idx_q, cnt_q};
        end
    end

    // Frame state: capture the request, advance per word, end on the last word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx_q  <= '0;
            cnt_q  <= '0;
            user_q <= '0;
        end else if (accept) begin
            active <= 1'b1;
            idx_q  <= req_idx;
            cnt_q  <= '0;
            user_q <= req_user;
        end else if (fire) begin
            if (last_word) begin
                active <= 1'b0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // Output: substitute the captured value on flagged words, zero when idle.
    always_comb begin
        busy      = active;
        out_valid = active;
        out_data  = '0;
        out_eof   = 1'b0;
        if (active) begin
            out_data = rd_q.repl ? user_q : rd_q.data;
            out_eof  = last_word;
        end
    end

    // A stalled word must stay put (R7).
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_eof)));

    // After the final word is taken the stream goes idle (R3).
    assert_eof_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eof) |=> !out_valid);

    // No bubble between words of a frame (R8).
    assert_no_bubble_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_eof) |=> out_valid);

    // An idle request is taken on the next edge (R6).
    assert_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> busy);

    // Busy persists until the final word is accepted (R6).
    assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(out_ready && out_eof)) |=> busy);

    // Idle outputs are zero (R10).
    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req) |=> (out_data == '0 && !out_eof));
endmodule

// File: rtl/tmpl_inject.sv
// Module: tmpl_inject
// Top level of the template injector: template store plus frame sequencer.
// Assumes NUM_TMPL * TMPL_DEPTH equals half of the offset space.
module tmpl_inject
    import tmpl_inject_pkg::*;
#(
    parameter int NUM_TMPL   = 8,
    parameter int TMPL_DEPTH = 64,
    parameter int OFFS_W     = 10,
    localparam int IDX_W     = $clog2(NUM_TMPL),
    localparam int DEPTH     = NUM_TMPL * TMPL_DEPTH,
    localparam int AW        = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [OFFS_W-1:0]    wr_offset,
    input  logic [ENTRY_W-1:0]   wr_data,
    input  logic                 req,
    input  logic [IDX_W-1:0]     req_idx,
    input  logic [WORD_W-1:0]    req_user,
    output logic                 busy,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [WORD_W-1:0]    out_data,
    output logic                 out_eof
);
    logic [AW-1:0] rd_addr;
    tmpl_word_t    rd_q;

    tmpl_store #(
        .OFFS_W (OFFS_W),
        .DEPTH  (DEPTH)
    ) i_store (
        .clk       (clk),
        .wr_en     (wr_en),
        .wr_offset (wr_offset),
        .wr_data   (tmpl_word_t'(wr_data)),
        .rd_addr   (rd_addr),
        .rd_q      (rd_q)
    );

    tmpl_seq #(
        .NUM_TMPL   (NUM_TMPL),
        .TMPL_DEPTH (TMPL_DEPTH)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_idx   (req_idx),
        .req_user  (req_user),
        .busy      (busy),
        .rd_addr   (rd_addr),
        .rd_q      (rd_q),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_eof   (out_eof)
    );
endmodule

// File: tb/test_tmpl_inject.sv
// Bench: directed scenarios for tmpl_inject, each task checks its own results.
module test_tmpl_inject;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [9:0]  wr_offset;
    logic [17:0] wr_data;
    logic        req;
    logic [2:0]  req_idx;
    logic [15:0] req_user;
    logic        busy;
    logic        out_valid;
    logic        out_ready;
    logic [15:0] out_data;
    logic        out_eof;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    logic [17:0] exp_mem [512];

    always #2.5 clk = ~clk;

    tmpl_inject i_tmpl_inject (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_offset (wr_offset),
        .wr_data   (wr_data),
        .req       (req),
        .req_idx   (req_idx),
        .req_user  (req_user),
        .busy      (busy),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_eof   (out_eof)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h at %0t", rq, act, exp, $time);
        end
    endtask

    // Write one store word through the port and mirror it in the model.
    task automatic put_word(input int slot, input int w, input logic [15:0] d,
                            input bit last, input bit repl);
        @(negedge clk);
        wr_en     = 1'b1;
        wr_offset = 10'(512 + slot * 64 + w);
        wr_data   = {repl, last, d};
        exp_mem[slot * 64 + w] = {repl, last, d};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Scenario R9: outputs after reset.
    task automatic t_reset;
        @(negedge clk);
        chk(busy == 1'b0, "R9 busy", 32'(busy), 0);
        chk(out_valid == 1'b0, "R9 valid", 32'(out_valid), 0);
        chk(out_data == 16'h0, "R10 data", 32'(out_data), 0);
        chk(out_eof == 1'b0, "R10 eof", 32'(out_eof), 0);
    endtask

    // Play one frame; stall: 0 = ready high, 1 = periodic stalls; spam: extra requests while busy.
    task automatic t_frame(input int slot, input logic [15:0] user, input int stall, input bit spam);
        int w = 0;
        int cyc = 0;
        @(negedge clk);
        req = 1'b1; req_idx = 3'(slot); req_user = user;
        @(negedge clk);
        req = 1'b0; req_user = ~user;          // R4: late change must not matter
        req_idx = 3'(slot + 1);
        chk(busy == 1'b1, "R6 busy after accept", 32'(busy), 1);
        forever begin
            logic [17:0] e = exp_mem[slot * 64 + w];
            logic [15:0] ed = e[17] ? user : e[15:0];
            bit ee = e[16] || (w == 63);
            bit rdy = (stall == 0) ? 1'b1 : ((cyc % 3) != 0);
            chk(out_valid == 1'b1, "R8 valid in frame", 32'(out_valid), 1);
            chk(out_data == ed, e[17] ? "R4 replaced word" : "R2 word data", 32'(out_data), 32'(ed));
            chk(out_eof == ee, (w == 63) ? "R5 cap eof" : "R3 eof flag", 32'(out_eof), 32'(ee));
            chk(busy == 1'b1, "R6 busy held", 32'(busy), 1);
            out_ready = rdy;
            req = spam && (w == 1) && !ee;
            @(negedge clk);
            req = 1'b0;
            cyc++;
            if (rdy) begin
                if (ee) break;
                w++;
            end
            if (cyc > 400) begin
                chk(1'b0, "R3 frame too long", 32'(cyc), 0);
                break;
            end
        end
        out_ready = 1'b0;
        chk(out_valid == 1'b0, "R3 idle after last", 32'(out_valid), 0);
        chk(busy == 1'b0, "R6 busy cleared", 32'(busy), 0);
        chk(out_data == 16'h0, "R10 idle data", 32'(out_data), 0);
        chk(out_eof == 1'b0, "R10 idle eof", 32'(out_eof), 0);
        @(negedge clk);
        chk(busy == 1'b0, "R6 ignored request not started", 32'(busy), 0);
    endtask

    // Scenario R1: a low-half write must not disturb slot 0 word 2.
    task automatic t_low_write;
        @(negedge clk);
        wr_en = 1'b1; wr_offset = 10'd2; wr_data = 18'h3ffff;
        @(negedge clk);
        wr_en = 1'b0;
        t_frame(0, 16'hbeef, 0, 1'b0);      // R1 checked via stored word 2
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_offset = '0; wr_data = '0;
        req = 1'b0; req_idx = '0; req_user = '0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && out_valid == 1'b0, "R9 in reset", 32'({busy, out_valid}), 0);
        rst_n = 1'b1;
        t_reset();

        // Slot 0: five words, word 2 replaced, word 4 last.
        for (int i = 0; i < 5; i++)
            put_word(0, i, 16'h1000 + 16'(i), i == 4, i == 2);
        // Slot 3: 64 words, no last flag.
        for (int i = 0; i < 64; i++)
            put_word(3, i, 16'h3300 + 16'(i), 1'b0, 1'b0);
        // Slot 7: a single last word.
        put_word(7, 0, 16'h7a7a, 1'b1, 1'b0);
        // Slot 5: ten words, first and last replaced.
        for (int i = 0; i < 10; i++)
            put_word(5, i, 16'h5500 + 16'(i), i == 9, (i == 0) || (i == 9));

        t_frame(0, 16'hcafe, 0, 1'b0);   // R2 R3 R4 R8
        t_frame(3, 16'h0000, 0, 1'b0);   // R5
        t_frame(7, 16'h1111, 0, 1'b0);   // R3 single word
        t_frame(5, 16'h2468, 1, 1'b0);   // R7 stalls, R4
        t_frame(5, 16'h9abc, 0, 1'b1);   // R6 requests while busy
        t_frame(3, 16'h0f0f, 1, 1'b1);   // R5 R7 under stalls
        t_low_write();                   // R1

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule